// File: doc/BRIEF.md
# Preamble-Aligned Audio Clock Divider

This block derives three timing outputs from the receiver's system clock: a data clock at one quarter of the system rate, a word clock at 1/256 of it, and a block sync pulse at 1/49152 of it. A block is 192 words of 256 system clocks each. All three outputs come from one position counter, so their edges always keep a fixed relation to each other.

The counter has two parts: a position within the word (0 to 255) and a word index within the block (0 to 191). The stream decoder upstream sends single-cycle strobes when it sees a word preamble or a block preamble. A block strobe returns the counter to the start of the block. A word strobe moves it to the start of the next word. Strobes that arrive exactly when the counter would roll over anyway leave the outputs unchanged. If no strobes arrive, the counter runs freely and wraps once per block.

Top module: `acg_clock_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it, the counter is at word 0, position 0. The outputs are then dclk_o=0, wclk_o=1, bsync_o=1.
- R2: dclk_o equals bit 1 of the position within the word. It has a period of 4 system clocks and is high for 2 of them.
- R3: wclk_o is high for positions 0 to 127 of each word and low for positions 128 to 255. Its period is 256 system clocks.
- R4: bsync_o is high only for positions 0 to 127 of word 0. Its period is 49152 system clocks.
- R5: A block strobe sampled at a clock edge moves the counter to word 0, position 0 at that edge. The outputs reflect this in the same cycle (dclk_o=0, wclk_o=1, bsync_o=1).
- R6: A word strobe, with no block strobe, moves the counter to position 0 of the next word at that edge. From word 191, the next word is word 0.
- R7: When both strobes arrive in the same cycle, the block strobe takes effect.
- R8: With no strobes, the position counts up by one per cycle. After position 255 it returns to 0 and the word index advances. After word 191, position 255, the counter returns to word 0, position 0.
- R9: A block strobe at word 191, position 255 leaves every output exactly as free running would. The same holds for a word strobe at position 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| word_stb_i | input | 1 | Single-cycle strobe: word preamble seen |
| blk_stb_i | input | 1 | Single-cycle strobe: block preamble seen |
| dclk_o | output | 1 | Data clock, system clock / 4 |
| wclk_o | output | 1 | Word clock, system clock / 256 |
| bsync_o | output | 1 | Block sync, system clock / 49152 |

## Verification
The hardest case to reach is a strobe arriving at exactly the last count of a word or block. Only there does the no-glitch property matter, and random strobes almost never hit it. The bench therefore keeps a model of the counter and waits until the model reaches word 191, position 255 (and later, position 255 of any word). It fires the strobe in that cycle and compares the outputs against a free-running model that ignores the strobe. Random sparse strobes, simultaneous strobes and one uninterrupted run of more than a full block cover the realignment and wrap cases.

// File: rtl/acg_pkg.sv
package acg_pkg;

    localparam int unsigned ACG_WORD_LEN    = 256;
    localparam int unsigned ACG_BLOCK_WORDS = 192;
    localparam int unsigned ACG_DCLK_BIT    = 1;
    localparam int unsigned ACG_BSYNC_LEN   = 128;

    typedef struct packed {
        logic dclk;
        logic wclk;
        logic bsync;
    } acg_clocks_t;

    // Output bundle for a counter sitting at the start of the block.
    function automatic acg_clocks_t acg_start_clocks();
        acg_clocks_t c;
        c.dclk  = 1'b0;
        c.wclk  = 1'b1;
        c.bsync = 1'b1;
        return c;
    endfunction

endpackage

// File: rtl/acg_counter.sv
module acg_counter #(
    parameter int unsigned WORD_LEN    = 256,
    parameter int unsigned BLOCK_WORDS = 192,
    localparam int unsigned POS_W      = $clog2(WORD_LEN),
    localparam int unsigned IDX_W      = $clog2(BLOCK_WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             word_stb,
    input  logic             blk_stb,
    output logic [POS_W-1:0] pos_q,
    output logic [IDX_W-1:0] idx_q,
    output logic [POS_W-1:0] pos_d,
    output logic [IDX_W-1:0] idx_d
);

    localparam logic [POS_W-1:0] POS_LAST = POS_W'(WORD_LEN - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BLOCK_WORDS - 1);

    logic [IDX_W-1:0] idx_inc;

    always_comb begin
        idx_inc = (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
    end

    always_comb begin
        if (blk_stb) begin
            pos_d = '0;
            idx_d = '0;
        end else if (word_stb || pos_q == POS_LAST) begin
            pos_d = '0;
            idx_d = idx_inc;
        end else begin
            pos_d = pos_q + 1'b1;
            idx_d = idx_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
            idx_q <= '0;
        end else begin
            pos_q <= pos_d;
            idx_q <= idx_d;
        end
    end

    // R5: block strobe lands the counter on the block start
    a_r5_block_realign: assert property (@(posedge clk) disable iff (rst)
        blk_stb |=> (pos_q == '0 && idx_q == '0));

    // R6: word strobe alone lands on position zero of the following word
    a_r6_word_realign: assert property (@(posedge clk) disable iff (rst)
        (word_stb && !blk_stb && idx_q != IDX_LAST) |=>
            (pos_q == '0 && idx_q == $past(idx_q) + 1'b1));

    // R8: free-running wrap at the end of the block
    a_r8_block_wrap: assert property (@(posedge clk) disable iff (rst)
        (!word_stb && !blk_stb && pos_q == POS_LAST && idx_q == IDX_LAST) |=>
            (pos_q == '0 && idx_q == '0));

    // R8: the word index never leaves its range
    a_r8_idx_range: assert property (@(posedge clk) disable iff (rst)
        idx_q <= IDX_LAST);

endmodule

// File: rtl/acg_decode.sv
module acg_decode
    import acg_pkg::*;
#(
    parameter int unsigned POS_W     = 8,
    parameter int unsigned IDX_W     = 8,
    parameter int unsigned DCLK_BIT  = 1,
    parameter int unsigned BSYNC_LEN = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [POS_W-1:0] pos_d,
    input  logic [IDX_W-1:0] idx_d,
    output acg_clocks_t      clocks_q
);

    localparam int unsigned POS_EXT = 32 - POS_W;

    acg_clocks_t clocks_d;

    always_comb begin
        clocks_d.dclk  = pos_d[DCLK_BIT];
        clocks_d.wclk  = ~pos_d[POS_W-1];
        clocks_d.bsync = (idx_d == '0) &&
                         ({{POS_EXT{1'b0}}, pos_d} < BSYNC_LEN);
    end

    // Registered from the next count so outputs line up with the counter.
    always_ff @(posedge clk) begin
        if (rst) begin
            clocks_q <= acg_start_clocks();
        end else begin
            clocks_q <= clocks_d;
        end
    end

endmodule

// File: rtl/acg_clock_gen.sv
module acg_clock_gen
    import acg_pkg::*;
#(
    parameter int unsigned WORD_LEN    = ACG_WORD_LEN,
    parameter int unsigned BLOCK_WORDS = ACG_BLOCK_WORDS,
    parameter int unsigned DCLK_BIT    = ACG_DCLK_BIT,
    parameter int unsigned BSYNC_LEN   = ACG_BSYNC_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic word_stb_i,
    input  logic blk_stb_i,
    output logic dclk_o,
    output logic wclk_o,
    output logic bsync_o
);

    localparam int unsigned POS_W = $clog2(WORD_LEN);
    localparam int unsigned IDX_W = $clog2(BLOCK_WORDS);

    logic [POS_W-1:0] pos_q;
    logic [IDX_W-1:0] idx_q;
    logic [POS_W-1:0] pos_d;
    logic [IDX_W-1:0] idx_d;
    acg_clocks_t      clocks;

    acg_counter #(
        .WORD_LEN    (WORD_LEN),
        .BLOCK_WORDS (BLOCK_WORDS)
    ) counter_i (
        .clk      (clk),
        .rst      (rst),
        .word_stb (word_stb_i),
        .blk_stb  (blk_stb_i),
        .pos_q    (pos_q),
        .idx_q    (idx_q),
        .pos_d    (pos_d),
        .idx_d    (idx_d)
    );

    acg_decode #(
        .POS_W     (POS_W),
        .IDX_W     (IDX_W),
        .DCLK_BIT  (DCLK_BIT),
        .BSYNC_LEN (BSYNC_LEN)
    ) decode_i (
        .clk      (clk),
        .rst      (rst),
        .pos_d    (pos_d),
        .idx_d    (idx_d),
        .clocks_q (clocks)
    );

    assign dclk_o  = clocks.dclk;
    assign wclk_o  = clocks.wclk;
    assign bsync_o = clocks.bsync;

    // R2: data clock rises when the count steps from phase 1 to phase 2
    a_r2_dclk_rise: assert property (@(posedge clk) disable iff (rst)
        (!word_stb_i && !blk_stb_i && pos_q[1:0] == 2'b01) |=> $rose(dclk_o));

    // R3: word clock is low only in the second half of a word
    a_r3_wclk_half: assert property (@(posedge clk) disable iff (rst)
        (wclk_o == ~pos_q[POS_W-1]));

    // R4: block sync never appears outside word zero
    a_r4_bsync_word0: assert property (@(posedge clk) disable iff (rst)
        bsync_o |-> (idx_q == '0));

    // R5: block strobe raises block sync on the next cycle
    a_r5_bsync_after_blk: assert property (@(posedge clk) disable iff (rst)
        blk_stb_i |=> (bsync_o && wclk_o && !dclk_o));

endmodule

// File: tb/acg_clock_gen_tb.sv
module acg_clock_gen_tb_top;

    localparam int WLEN   = 256;
    localparam int NWORDS = 192;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic word_stb = 1'b0;
    logic blk_stb  = 1'b0;
    logic dclk, wclk, bsync;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int mw = 0;
    int mp = 0;
    bit chk_en = 1'b0;
    bit free_model = 1'b0;
    string tag = "R1";

    always #10 clk = ~clk;

    acg_clock_gen dut_i (
        .clk        (clk),
        .rst        (rst),
        .word_stb_i (word_stb),
        .blk_stb_i  (blk_stb),
        .dclk_o     (dclk),
        .wclk_o     (wclk),
        .bsync_o    (bsync)
    );

    function automatic logic [2:0] exp_out(int w, int p);
        logic [2:0] e;
        e[2] = ((p >> 1) & 1) != 0;
        e[1] = (p < 128);
        e[0] = (w == 0) && (p < 128);
        return e;
    endfunction

    // Reference counter built from the requirements.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst || (!free_model && blk_stb)) begin
            mw <= 0;
            mp <= 0;
        end else if ((!free_model && word_stb) || mp == WLEN - 1) begin
            mp <= 0;
            mw <= (mw + 1) % NWORDS;
        end else begin
            mp <= mp + 1;
        end
    end

    task automatic check_now(string t);
        logic [2:0] e;
        e = exp_out(mw, mp);
        n_tests++;
        if ({dclk, wclk, bsync} !== e) begin
            n_fail++;
            $display("FAIL %s cyc=%0d w=%0d p=%0d actual={d,w,b}=%b expected=%b",
                     t, cyc, mw, mp, {dclk, wclk, bsync}, e);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en) check_now(tag);
    end

    always @(posedge clk) begin
        if (cyc == 190000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        chk_en = 1'b1;            // R1: reset values checked during reset
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);           // R1: first cycle after release

        // R5 R6 R2 R3: sparse random strobes
        tag = "R5/R6/R2/R3";
        for (int i = 0; i < 20000; i++) begin
            int r;
            r = int'($urandom % 1000);
            blk_stb  = (r < 3);
            word_stb = (r >= 3 && r < 13);
            @(negedge clk);
        end
        blk_stb = 1'b0; word_stb = 1'b0;

        // R7: both strobes together, mid-word
        tag = "R7";
        repeat (37) @(negedge clk);
        blk_stb = 1'b1; word_stb = 1'b1;
        @(negedge clk);
        blk_stb = 1'b0; word_stb = 1'b0;
        n_tests++;
        if (!(bsync && wclk && !dclk)) begin
            n_fail++;
            $display("FAIL R7 actual={d,w,b}=%b expected=011", {dclk, wclk, bsync});
        end
        // R6: word strobe from word 191
        tag = "R6";
        while (!(mw == NWORDS - 1 && mp == 5)) @(negedge clk);
        word_stb = 1'b1;
        @(negedge clk);
        word_stb = 1'b0;
        n_tests++;
        if (mw != 0 || !bsync) begin
            n_fail++;
            $display("FAIL R6 wrap actual bsync=%b expected=1", bsync);
        end

        // R8 R4: one full block plus margin with no strobes
        tag = "R8/R4";
        repeat (50000) @(negedge clk);

        // R9: strobes exactly at the expected counts, model ignores them
        tag = "R9";
        free_model = 1'b1;
        while (!(mw == NWORDS - 1 && mp == WLEN - 1)) @(negedge clk);
        blk_stb = 1'b1;
        @(negedge clk);
        blk_stb = 1'b0;
        repeat (300) @(negedge clk);
        while (mp != WLEN - 1) @(negedge clk);
        word_stb = 1'b1;
        @(negedge clk);
        word_stb = 1'b0;
        repeat (300) @(negedge clk);
        free_model = 1'b0;

        chk_en = 1'b0;
        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule